// File: doc/BRIEF.md
# Data Cache Tag State Checker

This block inspects one set of a four-way data cache after an error has been reported. It takes a cache index and walks through the ways of that set. For each way it reads the tag through a simple read port and captures the 5-bit coherence state. It flags any state outside the legal encodings. For lines in a legal state it checks the two parity bits that protect the physical tag. It also rebuilds each way's physical address and reports the bank, the set and the LRU ordering.

When data checking is requested, each way's tag read is followed by four doubleword reads. A bad-ECC verdict comes back from outside the block alongside each doubleword. The block collects these verdicts into a 4-bit offset mask. The ECC arithmetic and the cache arrays themselves are outside the block.

A request is accepted with `start` while the block is idle. `busy` covers the walk, and a one-cycle `done` marks the end. The results stay on the outputs until the next accepted `start`.

Top module: `dtag_checker`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en`, both error flags, `ecc_mask`, `lru_order`, every `way_state` field and every `way_pa` field are zero.
- R2: Reads are issued back to back, one per cycle, through ways 0 to 3 in order. For each way there is first a tag read (`rd_tag`=1) at address `{way, index}`. When data checking is on, four data reads (`rd_tag`=0) follow, at `{way, index} | (offset << 3)` for offsets 0, 1, 2 and 3 in that order.
- R3: Read data (`rd_tag_hi`, `rd_tag_lo`, `ecc_bad`) is sampled exactly one cycle after the cycle in which `rd_en` is high. Values presented in any other cycle have no effect.
- R4: `way_state[5w+4:5w]` holds bits 29:25 of way w's tag-high word.
- R5: The legal states are 0x00, 0x0F, 0x13, 0x16, 0x19 and 0x1C. Any other state in any way sets `tag_state_err`.
- R6: For a way in a legal state, `tag_addr_err` is set when tag-low bit 11 differs from the XOR of bits 39:26, or when bit 10 differs from the XOR of bits 25:13. A way in an illegal state never sets `tag_addr_err`.
- R7: `way_pa[40w+39:40w]` equals `{tag_lo[39:13], index}` for way w.
- R8: `bank` equals `{index[12], index[5]}`, and `set_idx` equals `index[11:6]`, for the index of the last accepted request.
- R9: `lru_order` equals bits 21:14 of way 0's tag-high word.
- R10: A bad-ECC verdict on the data read at offset k, in any way, sets `ecc_mask[3-k]`. `ecc_bad` has no effect during tag reads or when data checking is off.
- R11: `start` is accepted only while idle. `busy` rises on the next cycle. `done` is a one-cycle pulse, `2 + 4*(1 + 4*data_en)` cycles after acceptance, with `busy` low at that time. `start` during `busy` is ignored. Results are cleared on acceptance and held unchanged while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check of the given index |
| index | input | 13 | Cache index to inspect |
| data_en | input | 1 | Also read and check the data doublewords |
| rd_en | output | 1 | Read request to the cache arrays |
| rd_tag | output | 1 | 1 for a tag read, 0 for a data read |
| rd_addr | output | 15 | Read address: way in bits 14:13 |
| rd_tag_hi | input | 32 | Tag-high word, one cycle after the request |
| rd_tag_lo | input | 40 | Tag-low word, one cycle after the request |
| ecc_bad | input | 1 | External bad-ECC verdict for the data read |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| tag_state_err | output | 1 | Some way holds an illegal coherence state |
| tag_addr_err | output | 1 | Some legal way has a physical-tag parity mismatch |
| ecc_mask | output | 4 | Doubleword offsets with bad ECC, bit 3-k for offset k |
| way_state | output | 20 | Coherence state of each way, 5 bits per way |
| way_pa | output | 160 | Rebuilt physical address of each way, 40 bits per way |
| lru_order | output | 8 | LRU byte from way 0 |
| bank | output | 2 | Bank number of the index |
| set_idx | output | 6 | Set number of the index |

## Verification
The bench targets the corner cases where a plausible design goes wrong.

- A line in an illegal state that also has bad parity must raise only the state error. A design that checks parity on every way would raise the address error as well.
- The state 0x00 is legal even though it is not a valid line. A design that treats it as an error, or skips parity for it, is caught.
- The bench drives garbage on the read-data pins in every cycle without a request, and asserts `ecc_bad` during tag reads. A design that samples at the wrong latency, or takes the ECC verdict on a tag read, reports a wrong state, address or mask.
- A second `start` arrives mid-walk. A design that restarts would issue addresses that do not match the bench's expected read sequence.

// File: rtl/dtag_checker.sv
module dtag_checker #(
  parameter int IDX_W = 13,
  parameter int WAY_W = 2,
  parameter int HI_W  = 32,
  parameter int LO_W  = 40,
  parameter int ST_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [IDX_W-1:0]              index,
  input  logic                          data_en,
  output logic                          rd_en,
  output logic                          rd_tag,
  output logic [WAY_W+IDX_W-1:0]        rd_addr,
  input  logic [HI_W-1:0]               rd_tag_hi,
  input  logic [LO_W-1:0]               rd_tag_lo,
  input  logic                          ecc_bad,
  output logic                          busy,
  output logic                          done,
  output logic                          tag_state_err,
  output logic                          tag_addr_err,
  output logic [3:0]                    ecc_mask,
  output logic [(1<<WAY_W)*ST_W-1:0]    way_state,
  output logic [(1<<WAY_W)*LO_W-1:0]    way_pa,
  output logic [7:0]                    lru_order,
  output logic [1:0]                    bank,
  output logic [5:0]                    set_idx
);
  localparam int NWAYS  = 1 << WAY_W;
  localparam int ADDR_W = WAY_W + IDX_W;

  logic [IDX_W-1:0] idx_q;
  logic             dat_q, iss_done;
  logic [WAY_W-1:0] iss_way, rsp_way;
  logic [2:0]       iss_sub, rsp_sub;
  logic             rsp_v, rsp_last;
  logic [NWAYS-1:0][ST_W-1:0] st_q;
  logic [NWAYS-1:0][LO_W-1:0] pa_q;

  wire [2:0] sub_max    = dat_q ? 3'd4 : 3'd0;
  wire       last_issue = (iss_way == WAY_W'(NWAYS-1)) && (iss_sub == sub_max);
  wire [1:0] iss_off    = 2'(iss_sub - 3'd1);
  wire [1:0] rsp_off    = 2'(rsp_sub - 3'd1);

  assign rd_en   = busy && !iss_done;
  assign rd_tag  = (iss_sub == 3'd0);
  assign rd_addr = {iss_way, idx_q} | (rd_tag ? '0 : ADDR_W'({iss_off, 3'b000}));

  wire [ST_W-1:0] st_in = rd_tag_hi[29:25];
  wire st_legal = (st_in == 5'h00) || (st_in == 5'h0F) || (st_in == 5'h13) ||
                  (st_in == 5'h16) || (st_in == 5'h19) || (st_in == 5'h1C);
  wire par_bad  = (rd_tag_lo[11] != ^rd_tag_lo[39:26]) ||
                  (rd_tag_lo[10] != ^rd_tag_lo[25:13]);

  assign way_state = st_q;
  assign way_pa    = pa_q;
  assign bank      = {idx_q[12], idx_q[5]};
  assign set_idx   = idx_q[11:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; idx_q <= '0; dat_q <= 1'b0;
      iss_way <= '0; iss_sub <= '0; iss_done <= 1'b0;
      rsp_v <= 1'b0; rsp_way <= '0; rsp_sub <= '0; rsp_last <= 1'b0;
      st_q <= '0; pa_q <= '0; lru_order <= '0;
      tag_state_err <= 1'b0; tag_addr_err <= 1'b0; ecc_mask <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; idx_q <= index; dat_q <= data_en;
        iss_way <= '0; iss_sub <= '0; iss_done <= 1'b0; rsp_v <= 1'b0;
        st_q <= '0; pa_q <= '0; lru_order <= '0;
        tag_state_err <= 1'b0; tag_addr_err <= 1'b0; ecc_mask <= '0;
      end else if (busy) begin
        rsp_v    <= rd_en;
        rsp_way  <= iss_way;
        rsp_sub  <= iss_sub;
        rsp_last <= last_issue;
        if (rd_en) begin
          if (last_issue)
            iss_done <= 1'b1;
          else if (iss_sub == sub_max) begin
            iss_sub <= '0;
            iss_way <= iss_way + 1'b1;
          end else
            iss_sub <= iss_sub + 3'd1;
        end
        if (rsp_v) begin
          if (rsp_sub == 3'd0) begin
            st_q[rsp_way] <= st_in;
            pa_q[rsp_way] <= {rd_tag_lo[LO_W-1:IDX_W], idx_q};
            if (rsp_way == '0) lru_order <= rd_tag_hi[21:14];
            if (!st_legal)    tag_state_err <= 1'b1;
            else if (par_bad) tag_addr_err  <= 1'b1;
          end else if (ecc_bad) begin
            ecc_mask[2'd3 - rsp_off] <= 1'b1;
          end
          if (rsp_last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dtag_checker_chk.sv
module dtag_checker_chk #(
  parameter int IDX_W = 13,
  parameter int WAY_W = 2,
  parameter int LO_W  = 40,
  parameter int ST_W  = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic                       rd_en,
  input logic                       rd_tag,
  input logic [WAY_W+IDX_W-1:0]     rd_addr,
  input logic                       tag_state_err,
  input logic                       tag_addr_err,
  input logic [3:0]                 ecc_mask,
  input logic [(1<<WAY_W)*ST_W-1:0] way_state,
  input logic [(1<<WAY_W)*LO_W-1:0] way_pa,
  input logic [7:0]                 lru_order
);
  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
  // R2
  first_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rd_en && rd_tag && rd_addr[WAY_W+IDX_W-1:IDX_W] == '0));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(way_state) && $stable(way_pa) && $stable(ecc_mask) &&
                           $stable(tag_state_err) && $stable(tag_addr_err) && $stable(lru_order)));
endmodule

bind dtag_checker dtag_checker_chk #(.IDX_W(IDX_W), .WAY_W(WAY_W), .LO_W(LO_W), .ST_W(ST_W)) u_chk (.*);

// File: tb/test_dtag_checker.sv
module test_dtag_checker;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, data_en = 1'b0;
  logic [12:0] index = '0;
  logic rd_en, rd_tag, busy, done, tag_state_err, tag_addr_err, ecc_bad;
  logic [14:0] rd_addr;
  logic [31:0] rd_tag_hi;
  logic [39:0] rd_tag_lo;
  logic [3:0] ecc_mask;
  logic [19:0] way_state;
  logic [159:0] way_pa;
  logic [7:0] lru_order;
  logic [1:0] bank;
  logic [5:0] set_idx;

  int tests = 0, fails = 0;
  logic [31:0] th [4];
  logic [39:0] tl [4];
  logic        eb [4][4];
  int qway[$], qoff[$];
  logic [14:0] qaddr[$];

  always #10 clk = ~clk;

  dtag_checker i_dtag_checker (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Array model: responds one cycle after each request, garbage otherwise (R3)
  always @(posedge clk) begin
    if (rd_en) begin
      if (qaddr.size() == 0) begin
        chk(1'b0, "R2 unexpected read", 64'(rd_addr), 0);
        rd_tag_hi <= '1; rd_tag_lo <= '1; ecc_bad <= 1'b1;
      end else begin
        automatic int w = qway.pop_front();
        automatic int o = qoff.pop_front();
        automatic logic [14:0] a = qaddr.pop_front();
        chk(rd_addr == a, "R2 read address", 64'(rd_addr), 64'(a));
        chk(rd_tag == (o < 0), "R2 read kind", 64'(rd_tag), 64'(o < 0));
        rd_tag_hi <= th[w];
        rd_tag_lo <= tl[w];
        ecc_bad   <= (o < 0) ? 1'b1 : eb[w][o];
      end
    end else begin
      rd_tag_hi <= '1; rd_tag_lo <= '1; ecc_bad <= 1'b1;
    end
  end

  task automatic set_way(input int w, input logic [4:0] st, input int bad_par);
    th[w] = $urandom;
    th[w][29:25] = st;
    tl[w] = {8'($urandom), 32'($urandom)};
    tl[w][11] = ^tl[w][39:26];
    tl[w][10] = ^tl[w][25:13];
    if (bad_par == 1) tl[w][10] = ~tl[w][10];
    if (bad_par == 2) tl[w][11] = ~tl[w][11];
    for (int o = 0; o < 4; o++) eb[w][o] = 1'b0;
  endtask

  task automatic check_results(input logic [12:0] idx, input bit den, input string tag);
    logic es, ea;
    logic [3:0] m;
    es = 0; ea = 0; m = 0;
    for (int w = 0; w < 4; w++) begin
      automatic logic [4:0] st = th[w][29:25];
      automatic bit legal = st inside {5'h00, 5'h0F, 5'h13, 5'h16, 5'h19, 5'h1C};
      automatic logic [39:0] pa = (tl[w] & 40'hFF_FFFF_E000) | 40'(idx);
      if (!legal) es = 1;
      else if (tl[w][11] != ^tl[w][39:26] || tl[w][10] != ^tl[w][25:13]) ea = 1;
      if (den) for (int o = 0; o < 4; o++) if (eb[w][o]) m[3-o] = 1;
      chk(way_state[5*w +: 5] == st, {"R4 state ", tag}, 64'(way_state[5*w +: 5]), 64'(st));
      chk(way_pa[40*w +: 40] == pa, {"R7 address ", tag}, 64'(way_pa[40*w +: 40]), 64'(pa));
    end
    chk(tag_state_err == es, {"R5 state error ", tag}, 64'(tag_state_err), 64'(es));
    chk(tag_addr_err == ea, {"R6 parity error ", tag}, 64'(tag_addr_err), 64'(ea));
    chk(ecc_mask == m, {"R10 ecc mask ", tag}, 64'(ecc_mask), 64'(m));
    chk(lru_order == th[0][21:14], {"R9 lru ", tag}, 64'(lru_order), 64'(th[0][21:14]));
    chk(bank == {idx[12], idx[5]}, {"R8 bank ", tag}, 64'(bank), 64'({idx[12], idx[5]}));
    chk(set_idx == idx[11:6], {"R8 set ", tag}, 64'(set_idx), 64'(idx[11:6]));
  endtask

  task automatic run(input logic [12:0] idx, input bit den, input bit bump, input string tag);
    int n, cyc;
    n = 4 * (den ? 5 : 1);
    for (int w = 0; w < 4; w++) begin
      qway.push_back(w); qoff.push_back(-1); qaddr.push_back({2'(w), idx});
      if (den) for (int o = 0; o < 4; o++) begin
        qway.push_back(w); qoff.push_back(o);
        qaddr.push_back({2'(w), idx} | 15'(o << 3));
      end
    end
    @(negedge clk);
    index = idx; data_en = den; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    chk(busy == 1'b1, {"R11 busy after start ", tag}, 64'(busy), 1);
    while (!done && cyc < 100) begin
      if (bump && cyc == 3) begin
        start = 1'b1; index = ~idx; data_en = ~den;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == n + 2, {"R11 done timing ", tag}, 64'(cyc), 64'(n + 2));
    chk(!busy, {"R11 idle at done ", tag}, 64'(busy), 0);
    chk(qaddr.size() == 0, {"R2 all reads issued ", tag}, 64'(qaddr.size()), 0);
    check_results(idx, den, tag);
    @(negedge clk);
    chk(!done, {"R11 done one cycle ", tag}, 64'(done), 0);
    repeat (3) @(negedge clk);
    check_results(idx, den, {tag, " held"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !rd_en, "R1 control", 64'({busy, done, rd_en}), 0);
    chk(!tag_state_err && !tag_addr_err && ecc_mask == 0, "R1 flags", 64'({tag_state_err, tag_addr_err, ecc_mask}), 0);
    chk(way_state == 0 && way_pa == 0 && lru_order == 0, "R1 results", 64'(way_state), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // All legal, good parity, tags only; ecc_bad ignored (R10)
    set_way(0, 5'h0F, 0); set_way(1, 5'h13, 0); set_way(2, 5'h19, 0); set_way(3, 5'h1C, 0);
    eb[1][2] = 1;
    run(13'h1FE0, 1'b0, 1'b0, "legal tags-only");

    // Illegal state with bad parity: only R5 error, no R6
    set_way(0, 5'h16, 0); set_way(1, 5'h00, 0); set_way(2, 5'h05, 1); set_way(3, 5'h0F, 0);
    run(13'h1020, 1'b0, 1'b0, "illegal state");

    // Legal state 0x00 with bad tag parity in each segment (R6)
    set_way(0, 5'h1C, 0); set_way(1, 5'h00, 1); set_way(2, 5'h13, 0); set_way(3, 5'h19, 0);
    run(13'h0840, 1'b0, 1'b0, "ptag0 parity");
    set_way(0, 5'h1C, 0); set_way(1, 5'h0F, 0); set_way(2, 5'h13, 0); set_way(3, 5'h16, 2);
    run(13'h03A7, 1'b0, 1'b0, "ptag1 parity");

    // Data checking with bad ECC at offsets 0 and 3 in different ways (R10)
    set_way(0, 5'h0F, 0); set_way(1, 5'h1F, 0); set_way(2, 5'h19, 0); set_way(3, 5'h13, 0);
    eb[0][0] = 1; eb[3][3] = 1;
    run(13'h1FFF, 1'b1, 1'b0, "data ecc");

    // Data checking, no bad ECC, plus a start during busy that must be ignored (R11)
    set_way(0, 5'h13, 0); set_way(1, 5'h16, 0); set_way(2, 5'h0F, 0); set_way(3, 5'h00, 0);
    run(13'h0000, 1'b1, 1'b1, "restart ignored");

    // Single bad offset 1 to pin the bit order (R10)
    set_way(0, 5'h19, 0); set_way(1, 5'h19, 0); set_way(2, 5'h19, 0); set_way(3, 5'h19, 0);
    eb[2][1] = 1;
    run(13'h0A55, 1'b1, 1'b0, "offset1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule